// File: doc/BRIEF.md
# Serial Peripheral Control and Status Register Bank

This block is the register file in front of a serial port. Software reaches it through a 32-bit port that takes one request per cycle and uses byte offsets. Six control words each answer at four addresses, all in the same 16-byte slot:

- the base offset, which replaces the whole word;
- +4, which turns on the bits that are 1 in the write data;
- +8, which turns off the bits that are 1 in the write data;
- +0xC, which flips the bits that are 1 in the write data.

Software can therefore change single bits without a read-modify-write.

Two holding words (transmit data and divisor) sit next to the control words and have no aliases. So do two read-only inputs (status and debug) and a fixed version word.

The first control word carries a soft-reset bit and a clock-gate bit, and both are set after reset. Software clears the soft-reset bit first and the clock-gate bit second. Until both are low, the rest of the bank is frozen. The control words go to the serial datapath as a flat bus. The fields of the enable word also go out as separate wires.

Top module: `serial_csr_bank`

## Requirements
- R1: After reset, control word 0 (offset 0x00) reads 0xC000_0000. Bit 31 is soft reset and bit 30 is clock gate, and `soft_rst` and `clk_gate` are both 1. Every other control word and the data and divisor words read 0.
- R2: A write at a control word's base offset (0x00, 0x10, 0x20, 0x30, 0x40 or 0x50) replaces that word with the write data.
- R3: A write at base+0x4 ORs the write data into the control word.
- R4: A write at base+0x8 clears each bit of the control word whose write-data bit is 1.
- R5: A write at base+0xC inverts each bit of the control word whose write-data bit is 1.
- R6: A read at any of a control word's four addresses returns that word's current value.
- R7: The data word (0x60) and the divisor word (0xA0) take plain writes only. Their +4, +8 and +0xC addresses are unmapped.
- R8: The status word (0x70) returns `stat_in` and the debug word (0x90 is version, 0x80 is debug) returns `dbg_in`. A write to either offset changes nothing.
- R9: The version word (0x90) reads as major in bits 31:24, minor in bits 23:16 and step in bits 15:0, all taken from parameters.
- R10: While the soft-reset bit is 1, all other writable words are held at 0 and writes to them are dropped. A write that sets soft reset zeroes them at the same edge. A write that clears soft reset lets a write in the very next cycle land.
- R11: While the clock-gate bit is 1, writes to every word other than control word 0 are dropped. Control word 0 stays writable.
- R12: A read at an unaligned offset, or at an offset no word occupies, returns 0. A write there changes no word.
- R13: Control word 2 (offset 0x20) drives these outputs:
  - bit 0 drives `periph_en`;
  - bit 8 drives `tx_en`;
  - bit 9 drives `rx_en`;
  - bit 11 drives `rts_level`;
  - bit 14 drives `rts_auto`;
  - bit 15 drives `cts_flow`;
  - bit 24 drives `rx_dma_en`;
  - bit 25 drives `tx_dma_en`;
  - bit 26 drives `dma_on_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, registered, held between reads |
| stat_in | input | 32 | Live status from the datapath |
| dbg_in | input | 32 | Live debug value from the datapath |
| ctl_flat | output | 6*32 | Control words, with word i in bits i*32 +: 32 |
| data_q | output | 32 | Data holding word |
| baud_q | output | 32 | Divisor word |
| soft_rst | output | 1 | Soft-reset bit |
| clk_gate | output | 1 | Clock-gate bit |
| periph_en | output | 1 | Peripheral enable |
| tx_en | output | 1 | Transmit enable |
| rx_en | output | 1 | Receive enable |
| rts_level | output | 1 | Software RTS level |
| rts_auto | output | 1 | Automatic RTS |
| cts_flow | output | 1 | CTS flow control |
| rx_dma_en | output | 1 | Receive DMA enable |
| tx_dma_en | output | 1 | Transmit DMA enable |
| dma_on_err | output | 1 | Stop DMA on receive error |

## Verification
A write lands on the clock edge that samples it, so the bench drives every request on a falling edge and checks results only after the following rising edge. Read data is registered at that same edge and then held. The bench releases the strobe on the next falling edge and samples `rsp_rdata` there, exactly one edge after the request. Because the soft-reset clear depends on this one-edge rule, a write issued in the very next request slot is checked to land. The enable-field outputs are compared after the edge that wrote control word 2.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;

    localparam int REG_W  = 32;
    localparam int NCTL   = 6;
    localparam int CIDX_W = $clog2(NCTL);

    // slot index (offset bits 7:4) of the single-address words
    localparam logic [3:0] IDX_DATA = 4'd6;
    localparam logic [3:0] IDX_STAT = 4'd7;
    localparam logic [3:0] IDX_DBG  = 4'd8;
    localparam logic [3:0] IDX_VER  = 4'd9;
    localparam logic [3:0] IDX_BAUD = 4'd10;

    // control word 0
    localparam int SRST_BIT  = 31;
    localparam int CGATE_BIT = 30;

    // enable word (control word 2)
    localparam int EN_WORD       = 2;
    localparam int EN_PERIPH_BIT = 0;
    localparam int EN_TX_BIT     = 8;
    localparam int EN_RX_BIT     = 9;
    localparam int EN_RTS_BIT    = 11;
    localparam int EN_ARTS_BIT   = 14;
    localparam int EN_CTS_BIT    = 15;
    localparam int EN_RXDMA_BIT  = 24;
    localparam int EN_TXDMA_BIT  = 25;
    localparam int EN_DMAERR_BIT = 26;

    typedef enum logic [1:0] {
        OP_WR  = 2'd0,
        OP_SET = 2'd1,
        OP_CLR = 2'd2,
        OP_TOG = 2'd3
    } alias_op_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTL,
        SEL_DATA,
        SEL_STAT,
        SEL_DBG,
        SEL_VER,
        SEL_BAUD
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e          sel;
        logic [CIDX_W-1:0] ctl_idx;
        alias_op_e         op;
    } dec_t;

    function automatic logic [REG_W-1:0] alias_apply(
        input logic [REG_W-1:0] cur,
        input logic [REG_W-1:0] wd,
        input alias_op_e        op
    );
        case (op)
            OP_SET:  return cur | wd;
            OP_CLR:  return cur & ~wd;
            OP_TOG:  return cur ^ wd;
            default: return wd;
        endcase
    endfunction

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
    import csr_bank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    logic       hi_set;
    logic [3:0] slot;
    logic [1:0] sub;

    generate
        if (ADDR_W > 8) begin : g_hi
            assign hi_set = |addr[ADDR_W-1:8];
        end else begin : g_nohi
            assign hi_set = 1'b0;
        end
    endgenerate

    assign slot = addr[7:4];
    assign sub  = addr[3:2];

    always_comb begin
        dec.sel     = SEL_NONE;
        dec.ctl_idx = '0;
        dec.op      = OP_WR;
        if (!hi_set && addr[1:0] == 2'b00) begin
            if (int'(slot) < NCTL) begin
                dec.sel     = SEL_CTL;
                dec.ctl_idx = slot[CIDX_W-1:0];
                dec.op      = alias_op_e'(sub);
            end else if (sub == 2'b00) begin
                case (slot)
                    IDX_DATA: dec.sel = SEL_DATA;
                    IDX_STAT: dec.sel = SEL_STAT;
                    IDX_DBG:  dec.sel = SEL_DBG;
                    IDX_VER:  dec.sel = SEL_VER;
                    IDX_BAUD: dec.sel = SEL_BAUD;
                    default:  dec.sel = SEL_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/csr_alias_reg.sv
module csr_alias_reg
    import csr_bank_pkg::*;
#(
    parameter logic [REG_W-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             wr_en,
    input  alias_op_e        op,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            q <= RESET_VAL;
        end else if (wr_en) begin
            q <= alias_apply(q, wdata, op);
        end
    end

    a_r2_plain_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !hold && op == OP_WR) |=> (q == $past(wdata)));

    a_r3_set_alias: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !hold && op == OP_SET) |=> ((q & $past(wdata)) == $past(wdata)));

    a_r4_clear_alias: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !hold && op == OP_CLR) |=> ((q & $past(wdata)) == '0));

    a_r5_toggle_alias: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !hold && op == OP_TOG) |=> (q == ($past(q) ^ $past(wdata))));

endmodule

// File: rtl/csr_read_mux.sv
module csr_read_mux
    import csr_bank_pkg::*;
#(
    parameter logic [7:0]  VER_MAJOR = 8'd1,
    parameter logic [7:0]  VER_MINOR = 8'd0,
    parameter logic [15:0] VER_STEP  = 16'd0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_req,
    input  reg_sel_e              sel,
    input  logic [CIDX_W-1:0]     ctl_idx,
    input  logic [NCTL*REG_W-1:0] ctl_flat,
    input  logic [REG_W-1:0]      data_q,
    input  logic [REG_W-1:0]      baud_q,
    input  logic [REG_W-1:0]      stat_in,
    input  logic [REG_W-1:0]      dbg_in,
    output logic [REG_W-1:0]      rdata
);

    localparam logic [REG_W-1:0] VER_WORD = {VER_MAJOR, VER_MINOR, VER_STEP};

    logic [REG_W-1:0] rd_val;

    always_comb begin
        case (sel)
            SEL_CTL:  rd_val = ctl_flat[int'(ctl_idx)*REG_W +: REG_W];
            SEL_DATA: rd_val = data_q;
            SEL_STAT: rd_val = stat_in;
            SEL_DBG:  rd_val = dbg_in;
            SEL_VER:  rd_val = VER_WORD;
            SEL_BAUD: rd_val = baud_q;
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_req) begin
            rdata <= rd_val;
        end
    end

    a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_req && sel == SEL_NONE) |=> (rdata == '0));

    a_r9_version_fields: assert property (@(posedge clk) disable iff (rst)
        (rd_req && sel == SEL_VER) |=>
            (rdata[31:24] == VER_MAJOR && rdata[23:16] == VER_MINOR && rdata[15:0] == VER_STEP));

    a_r8_status_live: assert property (@(posedge clk) disable iff (rst)
        (rd_req && sel == SEL_STAT) |=> (rdata == $past(stat_in)));

endmodule

// File: rtl/serial_csr_bank.sv
module serial_csr_bank
    import csr_bank_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  VER_MAJOR = 8'd1,
    parameter logic [7:0]  VER_MINOR = 8'd0,
    parameter logic [15:0] VER_STEP  = 16'd0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [31:0]           req_wdata,
    output logic [31:0]           rsp_rdata,
    input  logic [31:0]           stat_in,
    input  logic [31:0]           dbg_in,
    output logic [NCTL*REG_W-1:0] ctl_flat,
    output logic [31:0]           data_q,
    output logic [31:0]           baud_q,
    output logic                  soft_rst,
    output logic                  clk_gate,
    output logic                  periph_en,
    output logic                  tx_en,
    output logic                  rx_en,
    output logic                  rts_level,
    output logic                  rts_auto,
    output logic                  cts_flow,
    output logic                  rx_dma_en,
    output logic                  tx_dma_en,
    output logic                  dma_on_err
);

    localparam logic [REG_W-1:0] CTL0_RESET = (REG_W'(1) << SRST_BIT) | (REG_W'(1) << CGATE_BIT);

    dec_t dec;
    logic wr_req, rd_req;
    logic ctl0_wr;
    logic [REG_W-1:0] ctl0_next;
    logic srst_q, cgate_q, hold_rest, rest_open;
    logic [REG_W-1:0] ctl_q [NCTL];
    logic [REG_W-1:0] en_word;

    csr_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (req_addr),
        .dec  (dec)
    );

    assign wr_req = req_valid & req_write;
    assign rd_req = req_valid & ~req_write;

    // control word 0: always writable, never held
    assign ctl0_wr = wr_req && dec.sel == SEL_CTL && dec.ctl_idx == '0;

    csr_alias_reg #(.RESET_VAL(CTL0_RESET)) u_ctl0 (
        .clk   (clk),
        .rst   (rst),
        .hold  (1'b0),
        .wr_en (ctl0_wr),
        .op    (dec.op),
        .wdata (req_wdata),
        .q     (ctl_q[0])
    );

    // soft reset seen at the edge that sets it, released at the edge that clears it
    always_comb begin
        ctl0_next = ctl0_wr ? alias_apply(ctl_q[0], req_wdata, dec.op) : ctl_q[0];
    end

    assign srst_q    = ctl_q[0][SRST_BIT];
    assign cgate_q   = ctl_q[0][CGATE_BIT];
    assign hold_rest = ctl0_next[SRST_BIT];
    assign rest_open = ~srst_q & ~cgate_q;

    generate
        for (genvar i = 1; i < NCTL; i++) begin : g_ctl
            logic wr_i;
            assign wr_i = wr_req && rest_open && dec.sel == SEL_CTL
                          && dec.ctl_idx == CIDX_W'(i);
            csr_alias_reg #(.RESET_VAL('0)) u_ctl (
                .clk   (clk),
                .rst   (rst),
                .hold  (hold_rest),
                .wr_en (wr_i),
                .op    (dec.op),
                .wdata (req_wdata),
                .q     (ctl_q[i])
            );
        end
        for (genvar j = 0; j < NCTL; j++) begin : g_flat
            assign ctl_flat[j*REG_W +: REG_W] = ctl_q[j];
        end
    endgenerate

    csr_alias_reg #(.RESET_VAL('0)) u_data (
        .clk   (clk),
        .rst   (rst),
        .hold  (hold_rest),
        .wr_en (wr_req && rest_open && dec.sel == SEL_DATA),
        .op    (OP_WR),
        .wdata (req_wdata),
        .q     (data_q)
    );

    csr_alias_reg #(.RESET_VAL('0)) u_baud (
        .clk   (clk),
        .rst   (rst),
        .hold  (hold_rest),
        .wr_en (wr_req && rest_open && dec.sel == SEL_BAUD),
        .op    (OP_WR),
        .wdata (req_wdata),
        .q     (baud_q)
    );

    csr_read_mux #(
        .VER_MAJOR (VER_MAJOR),
        .VER_MINOR (VER_MINOR),
        .VER_STEP  (VER_STEP)
    ) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_req   (rd_req),
        .sel      (dec.sel),
        .ctl_idx  (dec.ctl_idx),
        .ctl_flat (ctl_flat),
        .data_q   (data_q),
        .baud_q   (baud_q),
        .stat_in  (stat_in),
        .dbg_in   (dbg_in),
        .rdata    (rsp_rdata)
    );

    assign en_word    = ctl_q[EN_WORD];
    assign soft_rst   = srst_q;
    assign clk_gate   = cgate_q;
    assign periph_en  = en_word[EN_PERIPH_BIT];
    assign tx_en      = en_word[EN_TX_BIT];
    assign rx_en      = en_word[EN_RX_BIT];
    assign rts_level  = en_word[EN_RTS_BIT];
    assign rts_auto   = en_word[EN_ARTS_BIT];
    assign cts_flow   = en_word[EN_CTS_BIT];
    assign rx_dma_en  = en_word[EN_RXDMA_BIT];
    assign tx_dma_en  = en_word[EN_TXDMA_BIT];
    assign dma_on_err = en_word[EN_DMAERR_BIT];

    // R10: nothing but control word 0 may be nonzero while soft reset is set
    a_r10_held_in_reset: assert property (@(posedge clk) disable iff (rst)
        srst_q |-> (ctl_flat[NCTL*REG_W-1:REG_W] == '0 && data_q == '0 && baud_q == '0));

    // R11: a gated write to another word leaves the bank unchanged
    a_r11_gate_blocks: assert property (@(posedge clk) disable iff (rst)
        (cgate_q && wr_req && !ctl0_wr) |=>
            ($stable(ctl_flat[NCTL*REG_W-1:REG_W]) && $stable(data_q) && $stable(baud_q)));

endmodule

// File: tb/serial_csr_bank_bench.sv
module serial_csr_bank_bench;

    localparam int NC = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [7:0] req_addr = '0;
    logic [31:0] req_wdata = '0, stat_in = '0, dbg_in = '0;
    logic [31:0] rsp_rdata, data_q, baud_q;
    logic [NC*32-1:0] ctl_flat;
    logic soft_rst, clk_gate, periph_en, tx_en, rx_en, rts_level, rts_auto;
    logic cts_flow, rx_dma_en, tx_dma_en, dma_on_err;

    int n_chk = 0, n_bad = 0;
    logic [31:0] m_ctl [NC];
    logic [31:0] m_data, m_baud;

    always #2.5 clk = ~clk;

    serial_csr_bank #(
        .ADDR_W(8), .VER_MAJOR(8'h02), .VER_MINOR(8'h05), .VER_STEP(16'h0107)
    ) u_serial_csr_bank (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .stat_in(stat_in), .dbg_in(dbg_in), .ctl_flat(ctl_flat),
        .data_q(data_q), .baud_q(baud_q), .soft_rst(soft_rst), .clk_gate(clk_gate),
        .periph_en(periph_en), .tx_en(tx_en), .rx_en(rx_en), .rts_level(rts_level),
        .rts_auto(rts_auto), .cts_flow(cts_flow), .rx_dma_en(rx_dma_en),
        .tx_dma_en(tx_dma_en), .dma_on_err(dma_on_err)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        int slot = int'(a[7:4]);
        if (a[1:0] != 2'b00) return 32'h0;
        if (slot < NC) return m_ctl[slot];
        if (a[3:2] != 2'b00) return 32'h0;
        case (slot)
            6:  return m_data;
            7:  return stat_in;
            8:  return dbg_in;
            9:  return 32'h0205_0107;
            10: return m_baud;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        int slot = int'(a[7:4]);
        if (a[1:0] != 2'b00) return "R12 unaligned";
        if (slot < NC) return (a[3:2] == 2'b00) ? "R2 ctl read" : "R6 alias read";
        if (a[3:2] != 2'b00) return (slot == 6 || slot == 10) ? "R7 no alias" : "R12 unmapped";
        case (slot)
            6, 10:  return "R7 plain word";
            7, 8:   return "R8 read-only";
            9:      return "R9 version";
            default: return "R12 unmapped";
        endcase
    endfunction

    // model of a write, per R2-R5, R7, R10-R12
    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        int slot = int'(a[7:4]);
        logic open_now = !m_ctl[0][31] && !m_ctl[0][30];
        if (a[1:0] != 2'b00) return;
        if (slot < NC) begin
            if (slot == 0 || open_now) begin
                case (a[3:2])
                    2'd0: m_ctl[slot] = d;
                    2'd1: m_ctl[slot] = m_ctl[slot] | d;
                    2'd2: m_ctl[slot] = m_ctl[slot] & ~d;
                    default: m_ctl[slot] = m_ctl[slot] ^ d;
                endcase
            end
        end else if (a[3:2] == 2'b00 && open_now) begin
            if (slot == 6) m_data = d;
            if (slot == 10) m_baud = d;
        end
        if (m_ctl[0][31]) begin
            for (int k = 1; k < NC; k++) m_ctl[k] = '0;
            m_data = '0;
            m_baud = '0;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] got);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        got = rsp_rdata;
    endtask

    task automatic rd_chk(input logic [7:0] a, input string tag);
        logic [31:0] g;
        rd(a, g);
        check(tag, g, exp_read(a));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired, run did not finish (all R)");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] g;
        m_ctl[0] = 32'hC000_0000;
        for (int k = 1; k < NC; k++) m_ctl[k] = '0;
        m_data = '0;
        m_baud = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h00, g); check("R1 ctl0 reset", g, 32'hC000_0000);
        rd(8'h20, g); check("R1 ctl2 reset", g, 32'h0);
        check("R1 soft_rst/clk_gate", {30'h0, soft_rst, clk_gate}, 32'h3);

        // R10 writes dropped while in soft reset
        wr(8'h20, 32'h0000_FFFF);
        rd(8'h20, g); check("R10 held in reset", g, 32'h0);
        wr(8'h08, 32'h8000_0000);
        rd(8'h00, g); check("R4 clear srst", g, 32'h4000_0000);

        // R11 clock gate blocks other words
        wr(8'h20, 32'h1);
        rd(8'h20, g); check("R11 gated ctl2", g, 32'h0);
        wr(8'h60, 32'h55);
        rd(8'h60, g); check("R11 gated data", g, 32'h0);
        wr(8'h08, 32'h4000_0000);
        rd(8'h00, g); check("R11 ctl0 still writable", g, 32'h0);

        // R2-R6 alias arithmetic on control word 2
        wr(8'h20, 32'h0000_1234);
        rd(8'h20, g); check("R2 plain", g, 32'h0000_1234);
        wr(8'h24, 32'h0000_0F00);
        rd(8'h24, g); check("R3 set / R6 alias read", g, 32'h0000_1F34);
        wr(8'h2C, 32'h0000_00FF);
        rd(8'h2C, g); check("R5 toggle", g, 32'h0000_1FCB);
        wr(8'h28, 32'h0000_1000);
        rd(8'h28, g); check("R4 clear", g, 32'h0000_0FCB);

        // R7 data and divisor words
        wr(8'h60, 32'h0000_00A5);
        rd(8'h60, g); check("R7 data write", g, 32'h0000_00A5);
        wr(8'h64, 32'hFFFF_FFFF);
        rd(8'h60, g); check("R7 set alias absent", g, 32'h0000_00A5);
        rd(8'h64, g); check("R7 alias reads zero", g, 32'h0);
        wr(8'hA0, 32'h0001_2345);
        rd(8'hA0, g); check("R7 divisor write", g, 32'h0001_2345);

        // R8 read-only words
        stat_in = 32'hDEAD_BEEF;
        dbg_in  = 32'h1357_9BDF;
        wr(8'h70, 32'h0);
        rd(8'h70, g); check("R8 status", g, 32'hDEAD_BEEF);
        rd(8'h80, g); check("R8 debug", g, 32'h1357_9BDF);

        // R9 version
        rd(8'h90, g); check("R9 version", g, 32'h0205_0107);

        // R12 unmapped and unaligned
        rd(8'h22, g); check("R12 unaligned read", g, 32'h0);
        rd(8'hB0, g); check("R12 hole read", g, 32'h0);
        wr(8'hF0, 32'hFFFF_FFFF);
        wr(8'h21, 32'hFFFF_FFFF);
        rd(8'h20, g); check("R12 write no effect", g, 32'h0000_0FCB);

        // R13 enable fields
        wr(8'h20, 32'h0700_CB01);
        @(negedge clk);
        check("R13 enable outputs",
              {23'h0, periph_en, tx_en, rx_en, rts_level, rts_auto, cts_flow,
               rx_dma_en, tx_dma_en, dma_on_err}, 32'h1FF);
        wr(8'h20, 32'h0);
        @(negedge clk);
        check("R13 enable outputs low",
              {23'h0, periph_en, tx_en, rx_en, rts_level, rts_auto, cts_flow,
               rx_dma_en, tx_dma_en, dma_on_err}, 32'h0);

        // R10 setting srst zeroes the rest; clearing it opens at once
        wr(8'h20, 32'h0000_0301);
        wr(8'h04, 32'h8000_0000);
        rd(8'h20, g); check("R10 zeroed by srst", g, 32'h0);
        rd(8'hA0, g); check("R10 divisor zeroed", g, 32'h0);
        wr(8'h08, 32'h8000_0000);
        wr(8'h30, 32'h0000_0077);
        rd(8'h30, g); check("R10 write next cycle", g, 32'h0000_0077);

        // mixed random traffic against the model
        void'($urandom(32'd4242));
        for (int n = 0; n < 600; n++) begin
            logic [7:0] a;
            logic [31:0] d;
            a = {4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)),
                 ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'b00};
            d = $urandom;
            if (a[7:4] == 4'h0 && $urandom_range(0, 3) != 0) d = d & 32'h3FFF_FFFF;
            stat_in = $urandom;
            dbg_in  = $urandom;
            if ($urandom_range(0, 1) == 0) wr(a, d);
            else rd_chk(a, tag_of(a));
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule